// File: doc/BRIEF.md
# Two-Level Turn-Off Timing Sequencer

This block sequences the gate of a power switch through three drive levels: full off, an intermediate plateau and full on. A turn-on request does not drive the gate at once. The block first opens a fixed discharge window on the external timing node. It then waits for a flag that reports the node's ramp has crossed its threshold, and only then selects the on level. The whole span from request to switch-on is counted in quantised ticks. That count is kept and reused as the plateau length for the next turn-off.

On a turn-off, the gate stays on for a short command delay, or a longer delay when the cause is a fault. It then sits at the plateau level for the stored duration before going to full off. A plateau, once entered, always runs its full length. When the request comes back during the plateau, the gate returns to on instead of reaching full off, so a short off-pulse never turns the switch fully off. Such returns are counted. After a set number of them in a row, the next plateau is forced to end in full off, which suppresses ringing. A turn-on that is withdrawn before switch-on leaves the gate off.

Top module: `plateau_off_seq`

## Requirements
- R1: Out of reset the gate level is off (code 0) and the discharge output is low. A turn-on starts only if the request has been seen low since reset and since the last entry to full off. A request held high through such an entry leaves the gate off.
- R2: A turn-on request drives the discharge output high for DISCH_CYCLES cycles, with the gate still off. The ramp flag is then awaited and is ignored during discharge. The on level (code 2) appears in the cycle after the flag is sampled.
- R3: The stored hold value equals floor(c / TICK_CYCLES), where c is the number of cycles from the first discharge cycle to the cycle in which the flag is sampled. It saturates at 2^HOLD_W-1. When the count saturates before the flag arrives, the gate switches on anyway and the saturated value is stored.
- R4: When the request drops while the gate is on, the on level holds for CMD_DLY_CYCLES cycles before the plateau (code 1) begins.
- R5: A fault while the gate is on holds the on level for FAULT_DLY_CYCLES cycles before the plateau. A fault takes precedence over the request. Any fault seen during the on level, the off delay or the plateau makes the plateau end in full off.
- R6: The plateau lasts hold*TICK_CYCLES+1 cycles. With the request low at its end, the gate goes to full off.
- R7: A request that drops before switch-on aborts the turn-on, and the gate never reaches the on level. This holds even when the ramp flag arrives in the same cycle as the drop.
- R8: A plateau is never shortened. If the request is high again at its end, the gate returns to the on level without passing through full off.
- R9: After RING_LIMIT consecutive plateau-to-on returns without an intervening full off, the next plateau ends in full off. The count restarts at each full off.
- R10: While the fault input is high, no turn-on starts, and a turn-on in progress is aborted to full off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| gateReq | input | 1 | Filtered gate request, high asks for on |
| faultOff | input | 1 | Fault-initiated turn-off, active high |
| rampDone | input | 1 | Timing node ramp has crossed its threshold |
| gateLevel | output | 2 | Selected drive level: 0 off, 1 plateau, 2 on |
| dischargeEn | output | 1 | Discharge the timing node |

## Verification
The bench builds the block with TICK_CYCLES=2, DISCH_CYCLES=3, CMD_DLY_CYCLES=2, FAULT_DLY_CYCLES=4, HOLD_W=4 and RING_LIMIT=3. A two-cycle tick makes the floor quantisation and the hold*2+1 plateau length visible with odd and even ramp times. The 4-bit hold lets a missing ramp flag reach saturation (on after 31 cycles, a 31-cycle plateau) within a short run. The unequal command and fault delays tell the two turn-off causes apart at the port. The ring limit of three lets four back-to-back short off-pulses show both the returns to on and the forced full off.

// File: rtl/plateau_pkg.sv
package plateau_pkg;

  typedef enum logic [1:0] {
    LVL_OFF     = 2'b00,
    LVL_PLATEAU = 2'b01,
    LVL_ON      = 2'b10
  } gateLvl_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_DISCH,
    ST_CHARGE,
    ST_ON,
    ST_OFFDLY,
    ST_PLATEAU
  } seqState_e;

  typedef enum logic [1:0] {
    DLY_DISCH,
    DLY_CMD,
    DLY_FAULT
  } dlySel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    clrTick;
    logic    clrMeas;
    logic    measEn;
    logic    storeHold;
    logic    clrPl;
    logic    plEn;
    logic    loadDly;
    dlySel_e dlySel;
    logic    decDly;
    logic    incRing;
    logic    clrRing;
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic dlyZero;
    logic plDone;
    logic measSat;
    logic ringFull;
  } dpStat_t;

endpackage

// File: rtl/plateau_seq_dp.sv
module plateau_seq_dp
  import plateau_pkg::*;
#(
  parameter int TICK_CYCLES      = 1,
  parameter int DISCH_CYCLES     = 10,
  parameter int CMD_DLY_CYCLES   = 4,
  parameter int FAULT_DLY_CYCLES = 5,
  parameter int HOLD_W           = 8,
  parameter int RING_LIMIT       = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCmd_t  cmd,
  output dpStat_t stat
);

  localparam int PRE_W    = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int DLY_MAX0 = (DISCH_CYCLES > CMD_DLY_CYCLES) ? DISCH_CYCLES : CMD_DLY_CYCLES;
  localparam int DLY_MAX  = (DLY_MAX0 > FAULT_DLY_CYCLES) ? DLY_MAX0 : FAULT_DLY_CYCLES;
  localparam int DLY_W    = $clog2(DLY_MAX + 1);
  localparam int RING_W   = $clog2(RING_LIMIT + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(TICK_CYCLES - 1);
  localparam logic [HOLD_W-1:0] HOLD_MAX  = {HOLD_W{1'b1}};
  localparam logic [RING_W-1:0] RING_TOP  = RING_W'(RING_LIMIT);

  logic [PRE_W-1:0]  preCnt;
  logic              tick;
  logic [HOLD_W-1:0] measCnt;
  logic [HOLD_W-1:0] holdReg;
  logic [HOLD_W-1:0] plCnt;
  logic [DLY_W-1:0]  dlyCnt;
  logic [DLY_W-1:0]  dlyInit;
  logic [RING_W-1:0] ringCnt;

  // tick prescaler, phase restarted at each measured or replayed interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (cmd.clrTick)     preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else                      preCnt <= preCnt + 1'b1;
  end
  assign tick = (preCnt == PRE_LAST);

  // live measurement of the turn-on delay, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              measCnt <= '0;
    else if (cmd.clrMeas)                   measCnt <= '0;
    else if (cmd.measEn && tick && !stat.measSat) measCnt <= measCnt + 1'b1;
  end
  assign stat.measSat = (measCnt == HOLD_MAX);

  // stored hold time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              holdReg <= '0;
    else if (cmd.storeHold) holdReg <= measCnt;
  end

  // plateau replay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  plCnt <= '0;
    else if (cmd.clrPl)                         plCnt <= '0;
    else if (cmd.plEn && tick && plCnt != HOLD_MAX) plCnt <= plCnt + 1'b1;
  end
  assign stat.plDone = (plCnt >= holdReg);

  // shared cycle delay counter for discharge window and off delays
  always_comb begin
    case (cmd.dlySel)
      DLY_CMD:   dlyInit = DLY_W'(CMD_DLY_CYCLES - 1);
      DLY_FAULT: dlyInit = DLY_W'(FAULT_DLY_CYCLES - 1);
      default:   dlyInit = DLY_W'(DISCH_CYCLES - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           dlyCnt <= '0;
    else if (cmd.loadDly)                dlyCnt <= dlyInit;
    else if (cmd.decDly && dlyCnt != '0) dlyCnt <= dlyCnt - 1'b1;
  end
  assign stat.dlyZero = (dlyCnt == '0);

  // consecutive plateau-to-on return counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             ringCnt <= '0;
    else if (cmd.clrRing)                  ringCnt <= '0;
    else if (cmd.incRing && !stat.ringFull) ringCnt <= ringCnt + 1'b1;
  end
  assign stat.ringFull = (ringCnt == RING_TOP);

  AST_MEAS_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.measEn && !cmd.clrMeas) |=> (measCnt >= $past(measCnt))); // R3

  AST_PLATEAU_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cmd.plEn |-> (plCnt <= holdReg)); // R6

  AST_RING_CAP: assert property (@(posedge clk) disable iff (!rstN)
    cmd.incRing |-> !stat.ringFull); // R9

  AST_STORE_NOT_IN_PLATEAU: assert property (@(posedge clk) disable iff (!rstN)
    cmd.plEn |=> $stable(holdReg)); // R6

endmodule

// File: rtl/plateau_seq_ctrl.sv
module plateau_seq_ctrl
  import plateau_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       gateReq,
  input  logic       faultOff,
  input  logic       rampDone,
  input  dpStat_t    stat,
  output dpCmd_t     cmd,
  output logic [1:0] gateLevel,
  output logic       dischargeEn
);

  seqState_e state, nextState;
  logic      armed;
  logic      faultLatched;
  gateLvl_e  lvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  // a new turn-on needs the request seen low since the last off entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armed <= 1'b0;
    else if (!gateReq)  armed <= 1'b1;
    else if (state != nextState && (state == ST_OFF || nextState == ST_OFF))
                        armed <= 1'b0;
  end

  // a fault seen after switch-on forces the plateau to end in full off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   faultLatched <= 1'b0;
    else if (nextState == ST_OFF) faultLatched <= 1'b0;
    else if (faultOff && (state == ST_ON || state == ST_OFFDLY || state == ST_PLATEAU))
                                 faultLatched <= 1'b1;
  end

  always_comb begin
    cmd       = '0;
    nextState = state;
    case (state)
      ST_OFF: begin
        cmd.clrRing = 1'b1;
        if (armed && gateReq && !faultOff) begin
          nextState   = ST_DISCH;
          cmd.clrTick = 1'b1;
          cmd.clrMeas = 1'b1;
          cmd.loadDly = 1'b1;
          cmd.dlySel  = DLY_DISCH;
        end
      end
      ST_DISCH: begin
        cmd.measEn = 1'b1;
        cmd.decDly = 1'b1;
        if (!gateReq || faultOff) nextState = ST_OFF;
        else if (stat.dlyZero)    nextState = ST_CHARGE;
      end
      ST_CHARGE: begin
        cmd.measEn = 1'b1;
        if (!gateReq || faultOff) nextState = ST_OFF;
        else if (rampDone || stat.measSat) begin
          nextState     = ST_ON;
          cmd.storeHold = 1'b1;
        end
      end
      ST_ON: begin
        if (faultOff) begin
          nextState   = ST_OFFDLY;
          cmd.loadDly = 1'b1;
          cmd.dlySel  = DLY_FAULT;
        end else if (!gateReq) begin
          nextState   = ST_OFFDLY;
          cmd.loadDly = 1'b1;
          cmd.dlySel  = DLY_CMD;
        end
      end
      ST_OFFDLY: begin
        cmd.decDly = 1'b1;
        if (stat.dlyZero) begin
          nextState   = ST_PLATEAU;
          cmd.clrTick = 1'b1;
          cmd.clrPl   = 1'b1;
        end
      end
      ST_PLATEAU: begin
        cmd.plEn = 1'b1;
        if (stat.plDone) begin
          if (gateReq && !faultOff && !faultLatched && !stat.ringFull) begin
            nextState   = ST_ON;
            cmd.incRing = 1'b1;
          end else begin
            nextState = ST_OFF;
          end
        end
      end
      default: nextState = ST_OFF;
    endcase
  end

  always_comb begin
    case (state)
      ST_ON, ST_OFFDLY: lvl = LVL_ON;
      ST_PLATEAU:       lvl = LVL_PLATEAU;
      default:          lvl = LVL_OFF;
    endcase
  end

  assign gateLevel   = lvl;
  assign dischargeEn = (state == ST_DISCH);

  AST_ARMED_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DISCH && $past(state) == ST_OFF) |->
      ($past(armed) && $past(gateReq) && !$past(faultOff))); // R1

  AST_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ON && $past(state) != ST_ON) |->
      ($past(state) == ST_CHARGE || $past(state) == ST_PLATEAU)); // R2

  AST_PLATEAU_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PLATEAU && $past(state) != ST_PLATEAU) |->
      ($past(state) == ST_OFFDLY)); // R4

  AST_FAULT_NO_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PLATEAU && faultOff) |=> (state != ST_ON)); // R5

  AST_SHORT_ON_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_DISCH || state == ST_CHARGE) && !gateReq) |=> (state == ST_OFF)); // R7

  AST_FAULT_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_DISCH || state == ST_CHARGE) && faultOff) |=> (gateLevel == 2'b00)); // R10

endmodule

// File: rtl/plateau_off_seq.sv
module plateau_off_seq
  import plateau_pkg::*;
#(
  parameter int TICK_CYCLES      = 1,
  parameter int DISCH_CYCLES     = 10,
  parameter int CMD_DLY_CYCLES   = 4,
  parameter int FAULT_DLY_CYCLES = 5,
  parameter int HOLD_W           = 8,
  parameter int RING_LIMIT       = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       gateReq,
  input  logic       faultOff,
  input  logic       rampDone,
  output logic [1:0] gateLevel,
  output logic       dischargeEn
);

  dpCmd_t  cmd;
  dpStat_t stat;

  plateau_seq_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .gateReq     (gateReq),
    .faultOff    (faultOff),
    .rampDone    (rampDone),
    .stat        (stat),
    .cmd         (cmd),
    .gateLevel   (gateLevel),
    .dischargeEn (dischargeEn)
  );

  plateau_seq_dp #(
    .TICK_CYCLES      (TICK_CYCLES),
    .DISCH_CYCLES     (DISCH_CYCLES),
    .CMD_DLY_CYCLES   (CMD_DLY_CYCLES),
    .FAULT_DLY_CYCLES (FAULT_DLY_CYCLES),
    .HOLD_W           (HOLD_W),
    .RING_LIMIT       (RING_LIMIT)
  ) dp_i (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .stat (stat)
  );

endmodule

// File: tb/plateau_off_seq_tb.sv
`timescale 1ns/1ps
module plateau_off_seq_tb_top;

  localparam int LV_OFF = 0;
  localparam int LV_PL  = 1;
  localparam int LV_ON  = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       gateReq = 1'b0;
  logic       faultOff = 1'b0;
  logic       rampDone = 1'b0;
  logic [1:0] gateLevel;
  logic       dischargeEn;

  int nChk = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  plateau_off_seq #(
    .TICK_CYCLES      (2),
    .DISCH_CYCLES     (3),
    .CMD_DLY_CYCLES   (2),
    .FAULT_DLY_CYCLES (4),
    .HOLD_W           (4),
    .RING_LIMIT       (3)
  ) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .gateReq     (gateReq),
    .faultOff    (faultOff),
    .rampDone    (rampDone),
    .gateLevel   (gateLevel),
    .dischargeEn (dischargeEn)
  );

  // ramp cycle, expected first on cycle, expected plateau length
  localparam int VEC_N = 7;
  localparam int VEC_RAMP [VEC_N] = '{0, 3, 4, 7, 10, 40, 5};
  localparam int VEC_ON   [VEC_N] = '{4, 4, 5, 8, 11, 31, 6};
  localparam int VEC_PL   [VEC_N] = '{3, 3, 5, 7, 11, 31, 5};

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic turnOn(input int c, output int onIdx, output int dis);
    gateReq  = 1'b1;
    rampDone = 1'b0;
    onIdx    = -1;
    dis      = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (dischargeEn) dis++;
      if (int'(gateLevel) == LV_ON) begin
        onIdx = k;
        break;
      end
      if (k == c) rampDone = 1'b1;
    end
    rampDone = 1'b0;
  endtask

  task automatic offPulse(input int width, input bit viaFault,
                          output int tail, output int plat, output int fin);
    tail = 0;
    plat = 0;
    fin  = -1;
    if (viaFault) faultOff = 1'b1;
    else          gateReq  = 1'b0;
    for (int k = 1; k < 200; k++) begin
      @(negedge clk);
      if (k == width) begin
        if (viaFault) faultOff = 1'b0;
        else          gateReq  = 1'b1;
      end
      if (int'(gateLevel) == LV_PL) plat++;
      else if (plat == 0 && int'(gateLevel) == LV_ON) tail++;
      else begin
        fin = int'(gateLevel);
        break;
      end
    end
  endtask

  task automatic watchOn(input int n, output int onSeen);
    onSeen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (int'(gateLevel) == LV_ON) onSeen++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int onIdx, dis, tail, plat, fin, seen;

    // R1: reset state, request held high through reset must not start
    gateReq = 1'b1;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    chk("R1 level after reset", int'(gateLevel), LV_OFF);
    chk("R1 discharge after reset", int'(dischargeEn), 0);
    watchOn(5, seen);
    chk("R1 no start without low request", seen, 0);
    chk("R1 no discharge without low request", int'(dischargeEn), 0);
    gateReq = 1'b0;
    cyc(2);

    // R2 R3 R4 R6: table walk
    for (int v = 0; v < VEC_N; v++) begin
      turnOn(VEC_RAMP[v], onIdx, dis);
      chk("R2 on cycle", onIdx, VEC_ON[v]);
      chk("R2 discharge cycles", dis, 3);
      cyc(3);
      offPulse(0, 1'b0, tail, plat, fin);
      chk("R4 command off tail", tail, 2);
      chk("R3 R6 plateau length", plat, VEC_PL[v]);
      chk("R6 final level", fin, LV_OFF);
      cyc(2);
    end

    // R8 R9: short off-pulses return to on, fourth forced off
    turnOn(4, onIdx, dis);
    chk("R2 on cycle ring setup", onIdx, 5);
    cyc(3);
    for (int r = 0; r < 3; r++) begin
      offPulse(1, 1'b0, tail, plat, fin);
      chk("R8 short off tail", tail, 2);
      chk("R8 short off plateau", plat, 5);
      chk("R8 short off returns on", fin, LV_ON);
    end
    offPulse(1, 1'b0, tail, plat, fin);
    chk("R9 forced off after limit", fin, LV_OFF);
    watchOn(6, seen);
    chk("R1 stays off after forced off", seen, 0);
    gateReq = 1'b0;
    cyc(2);
    turnOn(4, onIdx, dis);
    chk("R2 on after rearm", onIdx, 5);
    offPulse(1, 1'b0, tail, plat, fin);
    chk("R9 ring count restarted", fin, LV_ON);
    offPulse(0, 1'b0, tail, plat, fin);
    chk("R6 plateau after ring", plat, 5);
    chk("R6 full off after ring", fin, LV_OFF);
    cyc(2);

    // R5: fault off uses longer delay and ends off with request high
    turnOn(6, onIdx, dis);
    chk("R2 on cycle fault setup", onIdx, 7);
    cyc(2);
    offPulse(2, 1'b1, tail, plat, fin);
    chk("R5 fault off tail", tail, 4);
    chk("R5 fault plateau", plat, 7);
    chk("R5 fault ends off", fin, LV_OFF);
    watchOn(5, seen);
    chk("R5 stays off after fault", seen, 0);
    gateReq = 1'b0;
    cyc(2);

    // R5 R8: fault during a returning plateau forces full off
    turnOn(4, onIdx, dis);
    cyc(1);
    gateReq = 1'b0;
    cyc(1);
    gateReq = 1'b1;
    cyc(2);
    chk("R8 plateau not cut short", int'(gateLevel), LV_PL);
    faultOff = 1'b1;
    cyc(1);
    faultOff = 1'b0;
    watchOn(10, seen);
    chk("R5 fault in plateau no return", seen, 0);
    chk("R5 fault in plateau final", int'(gateLevel), LV_OFF);
    gateReq = 1'b0;
    cyc(2);

    // R10: fault aborts a turn-on in progress
    gateReq = 1'b1;
    cyc(4);
    faultOff = 1'b1;
    cyc(1);
    faultOff = 1'b0;
    rampDone = 1'b1;
    watchOn(8, seen);
    rampDone = 1'b0;
    chk("R10 fault aborts turn-on", seen, 0);
    chk("R10 no discharge after abort", int'(dischargeEn), 0);
    gateReq = 1'b0;
    cyc(2);

    // R10: fault blocks start, release starts discharge
    faultOff = 1'b1;
    gateReq  = 1'b1;
    dis = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (dischargeEn) dis++;
    end
    chk("R10 no discharge while fault", dis, 0);
    faultOff = 1'b0;
    cyc(1);
    chk("R10 discharge after release", int'(dischargeEn), 1);

    // R7: drop during discharge
    gateReq = 1'b0;
    watchOn(6, seen);
    chk("R7 abort in discharge", seen, 0);

    // R7: drop during ramp wait, flag in same cycle
    gateReq = 1'b1;
    cyc(6);
    gateReq  = 1'b0;
    rampDone = 1'b1;
    cyc(1);
    rampDone = 1'b0;
    watchOn(8, seen);
    chk("R7 abort in ramp wait", seen, 0);
    chk("R7 level after abort", int'(gateLevel), LV_OFF);
    cyc(1);

    turnOn(7, onIdx, dis);
    chk("R2 on after aborts", onIdx, 8);
    offPulse(0, 1'b0, tail, plat, fin);
    chk("R3 plateau after aborts", plat, 7);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule